// File: doc/BRIEF.md
# Infrared Serial Byte Transceiver

This block moves single bytes over a half-duplex infrared link that uses asynchronous framing. On the transmit side a byte is taken over a valid/ready handshake and wrapped in a frame. The frame has one start bit, eight data bits sent least significant first, one stop bit and no parity. Each zero bit becomes one short LED-on pulse at the start of its bit cell. Each one bit leaves the LED dark. The pulse width is fixed in clock cycles, so it is the same at every bit rate. It is not a fraction of the bit period.

On the receive side the photodiode input is synchronised and its rising edges are found. A rising edge while idle is taken as a start bit. Later bit cells are placed relative to that first pulse. Each cell is judged by whether a pulse arrived in a window centred on the place the pulse is expected. The received byte is delivered with a one-cycle strobe and a framing-error flag.

A two-bit select input picks one of three bit rates. The transmitter latches the rate for each frame it sends, and the receiver latches it for each frame it receives. The receiver is blind to its own LED while it transmits and for one bit time afterwards. The transmitter does not accept a byte while a reception is in progress.

Top module: `irda_sir_xcvr`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `ir_led` is 0 and `rx_valid` is 0. Once reset has fallen and no frame is active, `tx_ready` is 1.
- R2: `rate_sel` sets the bit period in clock cycles. Code 0 gives 1920 cycles, code 1 gives 480 and code 2 gives 160. Code 3 behaves like code 2.
- R3: Call the edge at which a byte is accepted A. Bit i of the frame occupies cycles A+i·P to A+(i+1)·P, where P is the bit period. Bit 0 is the start bit (value 0), bits 1 to 8 are the data bits with the least significant bit first, and bit 9 is the stop bit (value 1). For a zero bit, `ir_led` is high for exactly 30 cycles, beginning one cycle after the edge A+i·P. For a one bit, `ir_led` stays low for the whole cell.
- R4: A byte is accepted on a rising edge where both `tx_valid` and `tx_ready` are high. `tx_ready` is 0 from that edge until 10·P cycles later, and it is also 0 while a reception is in progress. Transmit and receive are never active at the same time.
- R5: The receiver turns a pulse frame from the detector back into the byte and raises `rx_valid` for exactly one cycle with `rx_data`. This works when every pulse after the start pulse arrives up to P/2−20 cycles early or late relative to its expected position.
- R6: A pulse inside the stop-bit cell still delivers the byte, but with `rx_ferr` = 1. With no such pulse, `rx_ferr` = 0.
- R7: The detector input has no effect while a frame is being sent or for one bit period after the stop bit ends. This includes the block's own LED echo.
- R8: A transmit acceptance and a start-pulse detection can fall on the same edge. In that case the transmit frame goes out unchanged and no byte is received.
- R9: A change of `rate_sel` during a frame does not alter that frame's bit period, on either the transmit side or the receive side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 18.432 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Bit-rate select code |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| ir_led | output | 1 | LED enable, high = LED on |
| ir_det | input | 1 | Photodiode detector, high = light seen |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_ferr | output | 1 | Framing error of the last received byte |

## Verification
The two functions that can meet on one edge are transmit acceptance and start-pulse detection by the receiver. The bench raises the detector input exactly two cycles before it offers a byte. Because of the synchroniser delay, the detected rising edge then lands on the very edge that accepts the byte. The case is judged at the ports: the LED frame must match the byte pulse for pulse, with correct spacing and width, and no received-byte strobe may appear afterwards. A related timing race, an echo or stray pulse just inside or just outside the blanking interval after transmission, is checked the same way.

// File: rtl/irda_pkg.sv
package irda_pkg;

  // Receiver sequencing states
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HALF = 2'd1,
    RX_DATA = 2'd2,
    RX_STOP = 2'd3
  } rx_state_e;

  // Maps a rate code to a bit period in clock cycles; code 3 aliases the fastest rate
  function automatic int unsigned bit_period(input logic [1:0] sel,
                                             input int unsigned slow,
                                             input int unsigned mid,
                                             input int unsigned fast);
    case (sel)
      2'd0:    return slow;
      2'd1:    return mid;
      default: return fast;
    endcase
  endfunction

endpackage

// File: rtl/irda_rate_mux.sv
module irda_rate_mux #(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned DIV_SLOW = 1920,
  parameter int unsigned DIV_MID  = 480,
  parameter int unsigned DIV_FAST = 160
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] period
);
  assign period = CNT_W'(irda_pkg::bit_period(sel, DIV_SLOW, DIV_MID, DIV_FAST));
endmodule

// File: rtl/irda_det_sync.sv
module irda_det_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // STAGES flops for metastability plus one for edge history
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/irda_tx.sv
module irda_tx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned PULSE_CYC = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  period_in,
  input  logic              rx_busy,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_start,
  output logic              tx_active,
  output logic [CNT_W-1:0]  tx_period,
  output logic              ir_led
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned FIDX_W  = $clog2(FRAME_W);

  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [FIDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   per_q;

  // R4: accept only when idle and the receiver is not mid-frame
  assign tx_ready  = ~busy & ~rx_busy;
  assign tx_start  = tx_valid & tx_ready;
  assign tx_active = busy;
  assign tx_period = per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '1;
      bit_idx <= '0;
      cnt     <= '0;
      per_q   <= '0;
      ir_led  <= 1'b0;
    end else begin
      // R3: pulse covers the first PULSE_CYC cycles of a zero-bit cell
      ir_led <= busy && !shreg[0] && (cnt < CNT_W'(PULSE_CYC));
      if (tx_start) begin
        busy    <= 1'b1;
        shreg   <= {1'b1, tx_data, 1'b0};
        bit_idx <= '0;
        cnt     <= '0;
        per_q   <= period_in;     // R9: rate frozen for this frame
      end else if (busy) begin
        if (cnt == per_q - CNT_W'(1)) begin
          cnt   <= '0;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          if (bit_idx == FIDX_W'(FRAME_W-1)) busy <= 1'b0;
          else                               bit_idx <= bit_idx + FIDX_W'(1);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // Observer of LED run length, used only by the checks below
  logic [CNT_W-1:0] chk_run;
  always_ff @(posedge clk) begin
    if (rst)         chk_run <= '0;
    else if (ir_led) chk_run <= chk_run + CNT_W'(1);
    else             chk_run <= '0;
  end

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ir_led) |-> (chk_run == CNT_W'(PULSE_CYC)));

  assert_pulse_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (ir_led && chk_run == CNT_W'(PULSE_CYC - 1)) |=> !ir_led);

  assert_idle_dark_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !ir_led);

  assert_accept_handshake_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(tx_valid) && !$past(rx_busy)));

  assert_rate_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(per_q));
endmodule

// File: rtl/irda_rx.sv
module irda_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  period_in,
  input  logic              det_rise,
  input  logic              tx_start,
  input  logic              tx_active,
  input  logic [CNT_W-1:0]  tx_period,
  output logic              rx_active,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr
);
  import irda_pkg::*;

  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   per_q;
  logic [CNT_W-1:0]   blank_cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               seen;
  logic               hit;
  logic               blanked;

  assign hit       = seen | det_rise;
  // R7: own echo is ignored during transmit and one bit period after
  assign blanked   = tx_active | (blank_cnt != '0);
  assign rx_active = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      per_q     <= '0;
      blank_cnt <= '0;
      idx       <= '0;
      shreg     <= '0;
      seen      <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_ferr   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;

      if (tx_active)              blank_cnt <= tx_period;
      else if (blank_cnt != '0)   blank_cnt <= blank_cnt - CNT_W'(1);

      case (state)
        RX_IDLE: begin
          // R8: a transmit acceptance on this edge wins over a start pulse
          if (det_rise && !blanked && !tx_start) begin
            state <= RX_HALF;
            per_q <= period_in;                       // R9
            cnt   <= (period_in >> 1) - CNT_W'(1);
            seen  <= 1'b0;
            idx   <= '0;
          end
        end
        RX_HALF: begin
          // Windows are centred on the expected pulse positions (R5)
          if (cnt == '0) begin
            state <= RX_DATA;
            cnt   <= per_q - CNT_W'(1);
            seen  <= det_rise;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shreg <= {~hit, shreg[DATA_W-1:1]};
            seen  <= 1'b0;
            cnt   <= per_q - CNT_W'(1);
            if (idx == IDX_W'(DATA_W-1)) state <= RX_STOP;
            else                         idx   <= idx + IDX_W'(1);
          end else begin
            seen <= hit;
            cnt  <= cnt - CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (cnt == '0) begin
            rx_valid <= 1'b1;
            rx_data  <= shreg;
            rx_ferr  <= hit;           // R6
            state    <= RX_IDLE;
          end else begin
            seen <= hit;
            cnt  <= cnt - CNT_W'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_from_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> ($past(state) == RX_STOP));

  assert_no_start_blanked_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> (!$past(tx_active) && ($past(blank_cnt) == '0)));

  assert_tx_wins_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> !$past(tx_start));

  assert_rx_rate_held_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_active && $past(rx_active)) |-> $stable(per_q));
endmodule

// File: rtl/irda_sir_xcvr.sv
module irda_sir_xcvr #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_SLOW    = 1920,
  parameter int unsigned DIV_MID     = 480,
  parameter int unsigned DIV_FAST    = 160,
  parameter int unsigned PULSE_CYC   = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rate_sel,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              ir_led,
  input  logic              ir_det,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr
);
  // The slowest divider is the largest count held anywhere
  localparam int unsigned CNT_W = $clog2(DIV_SLOW + 1);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] tx_period;
  logic             tx_start;
  logic             tx_active;
  logic             rx_active;
  logic             det_rise;

  irda_rate_mux #(
    .CNT_W(CNT_W), .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)
  ) u_rate (
    .sel(rate_sel), .period(period)
  );

  irda_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ir_det), .rise(det_rise)
  );

  irda_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_tx (
    .clk(clk), .rst(rst), .period_in(period), .rx_busy(rx_active),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_start(tx_start), .tx_active(tx_active), .tx_period(tx_period),
    .ir_led(ir_led)
  );

  irda_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .period_in(period), .det_rise(det_rise),
    .tx_start(tx_start), .tx_active(tx_active), .tx_period(tx_period),
    .rx_active(rx_active), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ferr(rx_ferr)
  );

  assert_half_duplex_R4: assert property (@(posedge clk) disable iff (rst)
    !(rx_active && tx_active));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ir_led && !rx_valid));
endmodule

// File: tb/tb_irda_sir_xcvr.sv
module tb_irda_sir_xcvr;
  localparam int PULSE = 30;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'd2;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       ir_led;
  logic       det_drv = 1'b0;
  logic       loop_en = 1'b0;
  logic       ir_det;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ferr;

  assign ir_det = det_drv | (loop_en & ir_led);

  always #2 clk = ~clk;   // 250 MHz

  irda_sir_xcvr dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .ir_led(ir_led),
    .ir_det(ir_det), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor: received bytes and LED pulses
  int         rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic       rx_last_ferr = 1'b0;
  int         rise_t [128];
  int         rise_w [128];
  int         n_rise = 0;
  logic       led_prev = 1'b0;
  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt       <= rx_cnt + 1;
      rx_last      <= rx_data;
      rx_last_ferr <= rx_ferr;
    end
    if (ir_led && !led_prev) rise_t[n_rise % 128] <= cyc;
    if (!ir_led && led_prev) begin
      rise_w[n_rise % 128] <= cyc - rise_t[n_rise % 128];
      n_rise <= n_rise + 1;
    end
    led_prev <= ir_led;
  end

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic mid_ready = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int per_of(input logic [1:0] s);
    return (s == 2'd0) ? 1920 : (s == 2'd1) ? 480 : 160;
  endfunction

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Offers a byte and returns the cycle number of the accepting edge
  task automatic send_tx(input logic [7:0] d, output int a, output int base);
    @(negedge clk);
    base     = n_rise;
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    a = cyc;
  endtask

  // Compares recorded LED pulses with the frame expected for byte d
  task automatic chk_tx(input int a, input int per, input logic [7:0] d,
                        input int base, input string req);
    logic [9:0] fr;
    int k, bad, act, exp;
    fr = {1'b1, d, 1'b0};
    k = base; bad = 0; act = 0; exp = 0;
    for (int i = 0; i < 10; i++) begin
      if (!fr[i]) begin
        if (k >= n_rise) begin
          if (bad == 0) begin act = -1; exp = a + 1 + i * per; end
          bad++;
        end else if (rise_t[k % 128] != a + 1 + i * per || rise_w[k % 128] != PULSE) begin
          if (bad == 0) begin act = rise_t[k % 128]; exp = a + 1 + i * per; end
          bad++;
        end
        k++;
      end
    end
    if (k != n_rise) begin
      if (bad == 0) begin act = n_rise - base; exp = k - base; end
      bad++;
    end
    check(bad == 0, req, "LED pulse timing/width/count", act, exp);
  endtask

  // Drives a pulse frame on the detector; jit shifts pulses after the start pulse
  task automatic emit(input int per, input logic [7:0] d, input bit stopz,
                      input int jit, input int chg_at, input logic [1:0] chg_sel);
    logic [9:0] fr;
    int last;
    bit on;
    fr = {~stopz, d, 1'b0};
    last = 9 * per + jit + PULSE + 4;
    for (int c = 0; c <= last; c++) begin
      on = 1'b0;
      for (int i = 0; i < 10; i++) begin
        int t;
        t = i * per + ((i > 0) ? jit : 0);
        if (!fr[i] && c >= t && c < t + PULSE) on = 1'b1;
      end
      det_drv = on;
      if (c == 3 * per) mid_ready = tx_ready;
      if (c == chg_at) rate_sel = chg_sel;
      @(negedge clk);
    end
    det_drv = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]        sel;
    logic [7:0]        data;
    logic              stopz;
    logic signed [7:0] jit;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{sel: 2'd0, data: 8'hA5, stopz: 1'b0, jit:  8'sd0},
    '{sel: 2'd1, data: 8'h3C, stopz: 1'b1, jit:  8'sd100},
    '{sel: 2'd2, data: 8'h00, stopz: 1'b0, jit: -8'sd40},
    '{sel: 2'd2, data: 8'hFF, stopz: 1'b1, jit:  8'sd40},
    '{sel: 2'd3, data: 8'h81, stopz: 1'b0, jit:  8'sd0},
    '{sel: 2'd2, data: 8'h5A, stopz: 1'b0, jit:  8'sd60}
  };

  // Watchdog
  always @(posedge clk) begin
    if (cyc == LIMIT && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int a, base, per, rc;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(ir_led == 1'b0, "R1", "ir_led in reset", ir_led, 0);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ir_led == 1'b0 && rx_valid == 1'b0, "R1", "outputs after reset",
          {ir_led, rx_valid}, 0);
    check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);

    // Table walk: transmit with echo looped back, then receive a frame
    for (int v = 0; v < NV; v++) begin
      rate_sel = VEC[v].sel;
      per = per_of(VEC[v].sel);
      loop_en = 1'b1;
      rc = rx_cnt;
      send_tx(VEC[v].data, a, base);
      wait_cyc(a + 10 * per - 1);
      check(tx_ready == 1'b0, "R4", "tx_ready last cycle of frame", tx_ready, 0);
      wait_cyc(a + 10 * per);
      check(tx_ready == 1'b1, "R4", "tx_ready after frame", tx_ready, 1);
      chk_tx(a, per, VEC[v].data, base, (v == 4) ? "R2" : "R3");
      wait_cyc(a + 11 * per + 10);
      check(rx_cnt == rc, "R7", "bytes received from own echo", rx_cnt - rc, 0);
      loop_en = 1'b0;
      rc = rx_cnt;
      mid_ready = 1'b1;
      emit(per, VEC[v].data, VEC[v].stopz, int'(VEC[v].jit), -1, 2'd0);
      wait_cyc(cyc + per + 40);
      check(mid_ready == 1'b0, "R4", "tx_ready while receiving", mid_ready, 0);
      check(rx_cnt == rc + 1 && rx_last == VEC[v].data, "R5", "received byte",
            (rx_cnt == rc + 1) ? int'(rx_last) : -1, int'(VEC[v].data));
      check(rx_last_ferr == VEC[v].stopz, "R6", "framing flag",
            rx_last_ferr, VEC[v].stopz);
    end

    // R7: pulse inside blanking ignored, pulse just after it starts a frame
    rate_sel = 2'd2;
    loop_en = 1'b1;
    rc = rx_cnt;
    send_tx(8'h0F, a, base);
    wait_cyc(a + 10 * 160 + 80);
    det_drv = 1'b1;
    repeat (PULSE) @(negedge clk);
    det_drv = 1'b0;
    wait_cyc(a + 11 * 160 + 40);
    check(rx_cnt == rc, "R7", "pulse within blanking", rx_cnt - rc, 0);
    det_drv = 1'b1;
    repeat (PULSE) @(negedge clk);
    det_drv = 1'b0;
    wait_cyc(cyc + 11 * 160);
    check(rx_cnt == rc + 1 && rx_last == 8'hFF && !rx_last_ferr, "R7",
          "lone pulse after blanking gives 0xFF", int'(rx_last), 255);
    loop_en = 1'b0;

    // R8: start pulse detection and transmit acceptance on the same edge
    rc = rx_cnt;
    @(negedge clk);
    det_drv = 1'b1;
    @(negedge clk);
    @(negedge clk);
    base = n_rise;
    check(tx_ready == 1'b1, "R8", "tx_ready at collision", tx_ready, 1);
    tx_data = 8'h55;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    a = cyc;
    repeat (PULSE - 3) @(negedge clk);
    det_drv = 1'b0;
    wait_cyc(a + 12 * 160);
    chk_tx(a, 160, 8'h55, base, "R8");
    check(rx_cnt == rc, "R8", "bytes received after collision", rx_cnt - rc, 0);

    // R9: rate change mid-frame on transmit and on receive
    rate_sel = 2'd1;
    send_tx(8'h96, a, base);
    rate_sel = 2'd2;
    wait_cyc(a + 10 * 480 + 5);
    chk_tx(a, 480, 8'h96, base, "R9");
    wait_cyc(a + 11 * 480 + 20);
    rate_sel = 2'd2;
    rc = rx_cnt;
    emit(160, 8'hC3, 1'b0, 0, 3 * 160, 2'd0);
    wait_cyc(cyc + 200);
    check(rx_cnt == rc + 1 && rx_last == 8'hC3, "R9", "rx byte with rate change",
          int'(rx_last), 195);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule